// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Status Flags

This block takes one asynchronous serial line and turns it into received 8-bit characters. Its timing comes from a clock-enable tick that runs at eight times the bit rate. The line first passes through a two-flop synchronizer. A falling edge on the synchronized line, seen on a tick, marks a possible start bit. The receiver checks that start bit again at its midpoint. It then samples each data bit in the middle of its bit time, least significant bit first, samples an optional parity bit, and samples the stop bit.

When the receiver samples the stop bit, it moves the character into a holding buffer. In that same cycle it updates the buffer-full, framing-error, parity-error and overrun flags, and it returns to idle straight away, whatever value the stop bit had. A host reads the character by checking `bufFull` and pulsing `rdStrobe`. That pulse empties the buffer and clears the error flags. The reception-active flag follows the receiver's own progress through a frame, and the host cannot clear it.

Top module: `uart_rx_status`

## Requirements
- R1: While reset is held and just after it is released, `rxData` is 0 and `bufFull`, `rxActive`, `frameErr`, `overrun` and `parityErr` are all 0.
- R2: A high-to-low change of the synchronized line, observed on a tick while idle, sets `rxActive`. If the line is high again when it is sampled 4 ticks later, the receiver drops back to idle and loads no character.
- R3: The receiver counts only the clock cycles on which `tickEn` is high. It samples one data bit every 8 ticks, starting 8 ticks after the start-bit midpoint, and the first bit received becomes bit 0 of `rxData`.
- R4: `parityMode` 2'b01 selects even parity and 2'b10 selects odd parity; in both cases one parity bit follows the data. The values 2'b00 and 2'b11 mean the frame has no parity bit. `parityErr` is set at the stop sample when parity is enabled and the received parity bit does not match the data.
- R5: `frameErr` is set at the stop sample when the stop bit is sampled as 0.
- R6: `bufFull` rises in the same cycle as the new `rxData` and the new error flags. One `rdStrobe` pulse clears `bufFull`, `frameErr`, `parityErr` and `overrun`. The error flags are never set while `bufFull` is 0.
- R7: If a character is loaded while `bufFull` is already set and there is no `rdStrobe` in that cycle, `overrun` is set and the new character replaces the old one.
- R8: `rxActive` falls at the stop sample, and `rdStrobe` has no effect on it.
- R9: The receiver is idle right after the stop sample. A start bit that begins before the nominal end of the stop bit is therefore received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Sampling enable, high once per 1/8 bit time |
| rxLine | input | 1 | Asynchronous serial input, idles high |
| parityMode | input | 2 | 00/11 none, 01 even, 10 odd; static during a frame |
| rdStrobe | input | 1 | Host read pulse: empties buffer, clears error flags |
| rxData | output | 8 | Last received character |
| bufFull | output | 1 | Unread character in buffer |
| rxActive | output | 1 | Frame reception in progress |
| frameErr | output | 1 | Stop bit sampled as 0 |
| overrun | output | 1 | Unread character was overwritten |
| parityErr | output | 1 | Parity bit mismatch |

## Verification
The hardest situation to create is the early return to idle. To expose it, the next start edge has to arrive after the stop sample but before a full stop bit has passed. The bench shortens one stop bit to 6 ticks and begins the next frame immediately. If the second character then arrives intact with `overrun` set, both characters were loaded. The start glitch and a read pulse sent in the middle of a frame are driven at exact clock offsets. A run with one tick every three clocks shows that the receiver counts ticks and not clock cycles.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // Strobes issued by the sequencer to the datapath, one cycle wide.
  typedef struct packed {
    logic shiftBit;   // capture a data bit
    logic capParity;  // capture the parity bit
    logic loadBuf;    // stop sample: move byte and flags into buffer
  } ctlStrobe_t;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 8,
  parameter int DATA_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       lineS,
  input  logic       parityOn,
  output ctlStrobe_t strobes,
  output logic       rxActive
);
  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int MID   = OVERSAMPLE / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             lastLine;
  logic             cntLast;
  logic             cntMid;

  assign cntLast = (cnt == CNT_W'(OVERSAMPLE - 1));
  assign cntMid  = (cnt == CNT_W'(MID - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      lastLine <= 1'b1;
    end else if (tickEn) begin
      lastLine <= lineS;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (lastLine && !lineS) state <= S_START;
        end
        S_START: begin
          if (cntMid) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= lineS ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (cntLast) begin
            cnt    <= '0;
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == BIT_W'(DATA_W - 1)) state <= parityOn ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (cntLast) begin
            cnt   <= '0;
            state <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (cntLast) begin
            cnt   <= '0;
            state <= S_IDLE;   // back to idle at the stop sample, any value
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.shiftBit  = tickEn && cntLast && (state == S_DATA);
    strobes.capParity = tickEn && cntLast && (state == S_PAR);
    strobes.loadBuf   = tickEn && cntLast && (state == S_STOP);
  end

  assign rxActive = (state != S_IDLE);
endmodule

// File: rtl/rx_dpath.sv
module rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  ctlStrobe_t        strobes,
  input  logic              rdStrobe,
  input  logic [1:0]        parityMode,
  output logic              lineS,
  output logic              parityOn,
  output logic [DATA_W-1:0] rxData,
  output logic              bufFull,
  output logic              frameErr,
  output logic              overrun,
  output logic              parityErr
);
  logic [1:0]        syncQ;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic              mismatch;

  assign lineS    = syncQ[1];
  assign parityOn = (parityMode == PAR_EVEN) || (parityMode == PAR_ODD);
  assign mismatch = ((^shiftReg) ^ parBit) != (parityMode == PAR_ODD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rxLine};
      if (strobes.shiftBit)  shiftReg <= {lineS, shiftReg[DATA_W-1:1]};
      if (strobes.capParity) parBit   <= lineS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData    <= '0;
      bufFull   <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
      parityErr <= 1'b0;
    end else if (strobes.loadBuf) begin
      rxData    <= shiftReg;
      bufFull   <= 1'b1;
      frameErr  <= ~lineS;
      parityErr <= parityOn & mismatch;
      overrun   <= (overrun | bufFull) & ~rdStrobe;
    end else if (rdStrobe) begin
      bufFull   <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
      parityErr <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 8,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              rxLine,
  input  logic [1:0]        parityMode,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              bufFull,
  output logic              rxActive,
  output logic              frameErr,
  output logic              overrun,
  output logic              parityErr
);
  ctlStrobe_t strobes;
  logic       lineS;
  logic       parityOn;

  rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .lineS(lineS),
    .parityOn(parityOn), .strobes(strobes), .rxActive(rxActive)
  );

  rx_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobes(strobes),
    .rdStrobe(rdStrobe), .parityMode(parityMode), .lineS(lineS),
    .parityOn(parityOn), .rxData(rxData), .bufFull(bufFull),
    .frameErr(frameErr), .overrun(overrun), .parityErr(parityErr)
  );
endmodule

// File: rtl/rx_status_checker.sv
module rx_status_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStrobe,
  input logic [DATA_W-1:0] rxData,
  input logic              bufFull,
  input logic              rxActive,
  input logic              frameErr,
  input logic              overrun,
  input logic              parityErr
);
  AST_FLAGS_NEED_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr || parityErr || overrun) |-> bufFull); // R6
  AST_FULL_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $fell(rxActive)); // R8
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> (!bufFull || $fell(rxActive))); // R6
  AST_DATA_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(rxActive) |-> $stable(rxData)); // R3
  AST_OVERRUN_AT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $fell(rxActive)); // R7
endmodule

bind uart_rx_status rx_status_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rxData(rxData),
  .bufFull(bufFull), .rxActive(rxActive), .frameErr(frameErr),
  .overrun(overrun), .parityErr(parityErr)
);

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;
  logic       clk = 1'b0;
  logic       rstN;
  logic       tickEn;
  logic       rxLine;
  logic [1:0] parityMode;
  logic       rdStrobe;
  logic [7:0] rxData;
  logic       bufFull, rxActive, frameErr, overrun, parityErr;

  int nTests = 0;
  int nFail  = 0;
  int tickDiv = 1;
  int tickPh  = 0;

  always #5 clk = ~clk;

  uart_rx_status u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxLine(rxLine),
    .parityMode(parityMode), .rdStrobe(rdStrobe), .rxData(rxData),
    .bufFull(bufFull), .rxActive(rxActive), .frameErr(frameErr),
    .overrun(overrun), .parityErr(parityErr)
  );

  // {mode[13:12], data[11:4], flipParity[3], stopBit[2], expPe[1], expFe[0]}
  localparam logic [13:0] VEC [8] = '{
    {2'b00, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b00, 8'hA3, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'b01, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b01, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'b10, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b10, 8'h07, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'b11, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    tickEn = 1'b0;
    forever begin
      @(negedge clk);
      if (tickPh >= tickDiv - 1) begin tickPh = 0; tickEn = 1'b1; end
      else begin tickPh++; tickEn = 1'b0; end
    end
  end

  task automatic holdBit(input logic v, input int ticks, input logic pulseRd);
    rxLine   = v;
    rdStrobe = pulseRd;
    @(negedge clk);
    rdStrobe = 1'b0;
    if (pulseRd) chk("R8 rxActive after mid-frame read", rxActive, 1);
    repeat (ticks * tickDiv - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic [1:0] mode, input logic flip,
                           input logic stopBit, input int stopTicks, input logic midRead);
    logic p;
    parityMode = mode;
    holdBit(1'b0, 8, 1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i], 8, midRead && (i == 4));
    if (mode == 2'b01 || mode == 2'b10) begin
      p = (^d) ^ (mode == 2'b10) ^ flip;
      holdBit(p, 8, 1'b0);
    end
    holdBit(stopBit, stopTicks, 1'b0);
  endtask

  task automatic idle(input int n);
    rxLine = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic readBuf;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; rxLine = 1'b1; rdStrobe = 1'b0; parityMode = 2'b00;
    repeat (5) @(negedge clk);
    chk("R1 rxData reset", rxData, 0);
    chk("R1 flags reset", {bufFull, rxActive, frameErr, overrun, parityErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flags after release", {bufFull, rxActive, frameErr, overrun, parityErr}, 0);
    idle(4);

    // Vector table: R3 data, R4 parity, R5 framing, R6 clear on read
    foreach (VEC[k]) begin
      sendFrame(VEC[k][11:4], VEC[k][13:12], VEC[k][3], VEC[k][2], 8, 1'b0);
      idle(16);
      chk("R3 data", rxData, VEC[k][11:4]);
      chk("R6 bufFull set", bufFull, 1);
      chk("R4 parityErr", parityErr, VEC[k][1]);
      chk("R5 frameErr", frameErr, VEC[k][0]);
      chk("R7 no overrun", overrun, 0);
      chk("R8 rxActive low after stop", rxActive, 0);
      readBuf();
      chk("R6 flags cleared by read", {bufFull, frameErr, overrun, parityErr}, 0);
    end

    // R2: short low pulse is rejected
    rxLine = 1'b0;
    repeat (2) @(negedge clk);
    rxLine = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 rxActive on start edge", rxActive, 1);
    repeat (10) @(negedge clk);
    chk("R2 glitch returns to idle", rxActive, 0);
    chk("R2 glitch loads nothing", bufFull, 0);

    // R8: mid-frame read does not end reception
    sendFrame(8'h5A, 2'b00, 1'b0, 1'b1, 8, 1'b1);
    idle(16);
    chk("R8 byte after mid-frame read", rxData, 8'h5A);
    readBuf();

    // R7: overrun
    sendFrame(8'h11, 2'b00, 1'b0, 1'b1, 8, 1'b0);
    idle(8);
    sendFrame(8'h22, 2'b00, 1'b0, 1'b1, 8, 1'b0);
    idle(16);
    chk("R7 overrun set", overrun, 1);
    chk("R7 new data replaces old", rxData, 8'h22);
    chk("R7 bufFull kept", bufFull, 1);
    readBuf();
    chk("R7 overrun cleared by read", overrun, 0);

    // R9: shortened stop bit, next frame back to back
    sendFrame(8'hC5, 2'b00, 1'b0, 1'b1, 6, 1'b0);
    sendFrame(8'h3A, 2'b00, 1'b0, 1'b1, 8, 1'b0);
    idle(16);
    chk("R9 second byte after short stop", rxData, 8'h3A);
    chk("R9 first byte was loaded", overrun, 1);
    chk("R9 no framing error", frameErr, 0);
    readBuf();

    // R3: sparse ticks, one every third clock
    tickDiv = 3;
    idle(12);
    sendFrame(8'h96, 2'b01, 1'b0, 1'b1, 8, 1'b0);
    idle(40);
    chk("R3 sparse tick data", rxData, 8'h96);
    chk("R4 sparse tick even parity ok", parityErr, 0);
    chk("R6 sparse tick bufFull", bufFull, 1);
    readBuf();
    tickDiv = 1;

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule